// File: doc/BRIEF.md
# Power-Management Interrupt Event Aggregator

This block collects power-management events into one level-sensitive system control interrupt. It holds two groups of event registers. The fixed group is one 16-bit status word with a 16-bit enable word beside it. The general-purpose group is a small byte window: status bytes sit in its lower half and enable bytes in its upper half. Hardware event inputs set status bits. Software reads the registers, clears status bits by writing ones, and sets enable bits directly, all through one byte-wide register port. A bank-select input picks between the two groups.

The interrupt is high while a qualifying event is both pending and enabled in either group. In the fixed group, only the timer, global-lock, power-button and RTC-alarm bits qualify. In the general-purpose group, only the hotplug bit of the first status/enable byte pair qualifies. The block also drives a timer-arm output. It tells an external PM timer that an overflow event is still wanted: the timer event is enabled and its status is not yet pending.

All outputs come straight from the register state. A write or an event taken at a clock edge is therefore reflected on the interrupt, the arm output and the read data right after that edge.

Top module: `sci_event_agg`

## Requirements
- R1: After reset, every status and enable bit of both groups reads 0, `sci` is low and `tmrArm` is low.
- R2: With `regBank`=0, byte addresses 0 to GPE_BYTES/2-1 are the general-purpose status bytes and the upper half are the matching enable bytes. An enable byte reads back exactly what was last written to it.
- R3: With `regBank`=1, address 0 is fixed status bits 7:0, address 1 is status bits 15:8, address 2 is enable bits 7:0 and address 3 is enable bits 15:8. The bit positions are: timer at bit 0, global lock at bit 5, power button at bit 8, RTC alarm at bit 10.
- R4: Status bits are write-one-to-clear, and a 0 written to a status bit leaves it unchanged. Software cannot set a status bit.
- R5: From the fixed group, `sci` is high when one of the timer, global-lock, power-button or RTC-alarm bits has both status and enable set. An enable with no pending status does not raise `sci`.
- R6: From the general-purpose group, `sci` is high when bit HOTPLUG_BIT (1) is set in both status byte 0 and enable byte 0. A pending hotplug status with that enable clear does not raise `sci`.
- R7: `sci` is the OR of the two group conditions. It drops once no qualifying pair remains. It changes only on a register write or an event.
- R8: `tmrArm` is high exactly while the timer enable bit is set and the timer status bit is clear.
- R9: A pulse on `powerDownReq` sets the power-button status bit, as `evtPwrBtn` does.
- R10: A pulse on `evtHotplug` sets bit 1 of general-purpose status byte 0 and no other bit.
- R11: When an event input and a software clear of the same status bit fall in the same cycle, the bit ends up set.
- R12: Enable bytes of the general-purpose group other than byte 0 can be read and written but have no effect on `sci`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Byte write strobe for the register port |
| regBank | input | 1 | 0 selects the general-purpose window, 1 the fixed group |
| regAddr | input | ADDR_W | Byte address within the selected bank |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Read data byte for regBank/regAddr |
| evtTmrOvf | input | 1 | Timer overflow event pulse |
| evtGlobalLock | input | 1 | Global lock release event pulse |
| evtPwrBtn | input | 1 | Power button event pulse |
| evtRtcAlarm | input | 1 | RTC alarm event pulse |
| powerDownReq | input | 1 | Power-down request; sets the power-button status |
| evtHotplug | input | 1 | Hotplug event pulse |
| sci | output | 1 | System control interrupt level |
| tmrArm | output | 1 | Requests arming of the timer overflow event |

## Verification
The bench builds the block with its defaults, GPE_BYTES=4 and HOTPLUG_BIT=1. This gives two status bytes and two enable bytes, so every byte address of both banks is reachable and the second enable byte serves as the non-qualifying case for R12. With the hotplug bit at 1, the check that the hotplug event sets nothing but 0x02 in byte 0 separates the qualifying bit from its neighbours. A same-cycle event-and-clear on the timer bit exercises the priority rule through both the read port and `tmrArm`.

// File: rtl/sci_agg_pkg.sv
package sci_agg_pkg;
  // bit positions inside the fixed 16-bit status/enable words
  localparam int BIT_TMR    = 0;
  localparam int BIT_GLBL   = 5;
  localparam int BIT_PWRBTN = 8;
  localparam int BIT_RTC    = 10;
  localparam logic [15:0] PM1_SCI_MASK =
    16'((1 << BIT_TMR) | (1 << BIT_GLBL) | (1 << BIT_PWRBTN) | (1 << BIT_RTC));

  // strobes from control to datapath for one register write
  typedef struct packed {
    logic       stsClr;   // write-one-to-clear on a status byte
    logic       enWr;     // plain write on an enable byte
    logic       isPm1;    // 1: fixed group, 0: general-purpose window
    logic [7:0] byteIdx;  // byte index within the status or enable half
    logic [7:0] data;
  } regStrobe_t;
endpackage

// File: rtl/sci_agg_ctrl.sv
module sci_agg_ctrl
  import sci_agg_pkg::*;
#(
  parameter int GPE_BYTES = 4,
  parameter int ADDR_W    = $clog2(GPE_BYTES)
) (
  input  logic              regWrEn,
  input  logic              regBank,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              evtTmrOvf,
  input  logic              evtGlobalLock,
  input  logic              evtPwrBtn,
  input  logic              evtRtcAlarm,
  input  logic              powerDownReq,
  input  logic              evtHotplug,
  output regStrobe_t        strb,
  output logic [15:0]       pm1Set,
  output logic              gpeHpSet
);
  localparam int HALF = GPE_BYTES / 2;

  always_comb begin
    strb       = '0;
    strb.data  = regWrData;
    strb.isPm1 = regBank;
    if (regBank) begin
      strb.byteIdx = {7'b0, regAddr[0]};
      strb.stsClr  = regWrEn & ~regAddr[1];
      strb.enWr    = regWrEn & regAddr[1];
    end else if (int'(regAddr) < HALF) begin
      strb.byteIdx = 8'(regAddr);
      strb.stsClr  = regWrEn;
    end else begin
      strb.byteIdx = 8'(int'(regAddr) - HALF);
      strb.enWr    = regWrEn;
    end
  end

  always_comb begin
    pm1Set             = '0;
    pm1Set[BIT_TMR]    = evtTmrOvf;
    pm1Set[BIT_GLBL]   = evtGlobalLock;
    pm1Set[BIT_PWRBTN] = evtPwrBtn | powerDownReq;
    pm1Set[BIT_RTC]    = evtRtcAlarm;
  end

  assign gpeHpSet = evtHotplug;
endmodule

// File: rtl/sci_agg_datapath.sv
module sci_agg_datapath
  import sci_agg_pkg::*;
#(
  parameter int GPE_BYTES   = 4,
  parameter int HOTPLUG_BIT = 1,
  parameter int ADDR_W      = $clog2(GPE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [15:0]       pm1Set,
  input  logic              gpeHpSet,
  input  logic              rdBank,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              sci,
  output logic              tmrArm
);
  localparam int HALF = GPE_BYTES / 2;

  logic [7:0]  gpeSts [HALF];
  logic [7:0]  gpeEn  [HALF];
  logic [15:0] pm1Sts;
  logic [15:0] pm1En;

  for (genvar g = 0; g < HALF; g++) begin : gGpe
    localparam logic [7:0] HP_MASK = (g == 0) ? 8'(1 << HOTPLUG_BIT) : 8'h00;
    logic hit;
    logic [7:0] clrMask;
    logic [7:0] setMask;
    assign hit     = !strb.isPm1 && (strb.byteIdx == 8'(g));
    assign clrMask = (hit && strb.stsClr) ? strb.data : 8'h00;
    assign setMask = gpeHpSet ? HP_MASK : 8'h00;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        gpeSts[g] <= '0;
        gpeEn[g]  <= '0;
      end else begin
        gpeSts[g] <= (gpeSts[g] & ~clrMask) | setMask;   // event wins
        if (hit && strb.enWr) gpeEn[g] <= strb.data;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : gPm1
    logic hit;
    logic [7:0] clrMask;
    assign hit     = strb.isPm1 && (strb.byteIdx == 8'(b));
    assign clrMask = (hit && strb.stsClr) ? strb.data : 8'h00;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pm1Sts[b*8 +: 8] <= '0;
        pm1En[b*8 +: 8]  <= '0;
      end else begin
        pm1Sts[b*8 +: 8] <= (pm1Sts[b*8 +: 8] & ~clrMask) | pm1Set[b*8 +: 8];
        if (hit && strb.enWr) pm1En[b*8 +: 8] <= strb.data;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdBank) begin
      case (rdAddr[1:0])
        2'd0:    rdData = pm1Sts[7:0];
        2'd1:    rdData = pm1Sts[15:8];
        2'd2:    rdData = pm1En[7:0];
        default: rdData = pm1En[15:8];
      endcase
    end else begin
      for (int i = 0; i < HALF; i++) begin
        if (int'(rdAddr) == i)        rdData = gpeSts[i];
        if (int'(rdAddr) == i + HALF) rdData = gpeEn[i];
      end
    end
  end

  logic pm1Hit;
  logic gpeHit;
  assign pm1Hit = |(pm1Sts & pm1En & PM1_SCI_MASK);
  assign gpeHit = gpeSts[0][HOTPLUG_BIT] & gpeEn[0][HOTPLUG_BIT];
  assign sci    = pm1Hit | gpeHit;
  assign tmrArm = pm1En[BIT_TMR] & ~pm1Sts[BIT_TMR];
endmodule

// File: rtl/sci_event_agg.sv
module sci_event_agg
  import sci_agg_pkg::*;
#(
  parameter int GPE_BYTES   = 4,
  parameter int HOTPLUG_BIT = 1,
  parameter int ADDR_W      = $clog2(GPE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regBank,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              evtTmrOvf,
  input  logic              evtGlobalLock,
  input  logic              evtPwrBtn,
  input  logic              evtRtcAlarm,
  input  logic              powerDownReq,
  input  logic              evtHotplug,
  output logic              sci,
  output logic              tmrArm
);
  regStrobe_t  strb;
  logic [15:0] pm1Set;
  logic        gpeHpSet;

  sci_agg_ctrl #(.GPE_BYTES(GPE_BYTES), .ADDR_W(ADDR_W)) i_ctrl (
    .regWrEn(regWrEn), .regBank(regBank), .regAddr(regAddr), .regWrData(regWrData),
    .evtTmrOvf(evtTmrOvf), .evtGlobalLock(evtGlobalLock), .evtPwrBtn(evtPwrBtn),
    .evtRtcAlarm(evtRtcAlarm), .powerDownReq(powerDownReq), .evtHotplug(evtHotplug),
    .strb(strb), .pm1Set(pm1Set), .gpeHpSet(gpeHpSet)
  );

  sci_agg_datapath #(.GPE_BYTES(GPE_BYTES), .HOTPLUG_BIT(HOTPLUG_BIT), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pm1Set(pm1Set), .gpeHpSet(gpeHpSet),
    .rdBank(regBank), .rdAddr(regAddr), .rdData(regRdData), .sci(sci), .tmrArm(tmrArm)
  );
endmodule

// File: rtl/sci_event_agg_checker.sv
module sci_event_agg_checker #(
  parameter int GPE_BYTES = 4,
  parameter int ADDR_W    = $clog2(GPE_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regBank,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic              evtTmrOvf,
  input logic              evtGlobalLock,
  input logic              evtPwrBtn,
  input logic              evtRtcAlarm,
  input logic              powerDownReq,
  input logic              evtHotplug,
  input logic              sci,
  input logic              tmrArm
);
  localparam int HALF = GPE_BYTES / 2;
  logic anyEvt;
  logic stsTarget;
  assign anyEvt = evtTmrOvf | evtGlobalLock | evtPwrBtn | evtRtcAlarm | powerDownReq | evtHotplug;
  assign stsTarget = regBank ? !regAddr[1] : (int'(regAddr) < HALF);

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rstN) |-> (!sci && !tmrArm));  // R1

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !anyEvt) |=> ($stable(sci) && $stable(tmrArm)));  // R7

  AST_ZERO_CLEAR_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && stsTarget && regWrData == 8'h00 && !anyEvt) |=> ($stable(sci) && $stable(tmrArm)));  // R4

  AST_TMR_EVT_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    evtTmrOvf |=> !tmrArm);  // R8

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (evtTmrOvf && regWrEn && regBank && regAddr[1:0] == 2'd0 && regWrData[0]) |=> !tmrArm);  // R11
endmodule

bind sci_event_agg sci_event_agg_checker #(.GPE_BYTES(GPE_BYTES), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regBank(regBank), .regAddr(regAddr),
  .regWrData(regWrData), .evtTmrOvf(evtTmrOvf), .evtGlobalLock(evtGlobalLock),
  .evtPwrBtn(evtPwrBtn), .evtRtcAlarm(evtRtcAlarm), .powerDownReq(powerDownReq),
  .evtHotplug(evtHotplug), .sci(sci), .tmrArm(tmrArm)
);

// File: tb/test_sci_event_agg.sv
module test_sci_event_agg;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regBank = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [7:0] regWrData = '0, regRdData;
  logic evtTmrOvf = 0, evtGlobalLock = 0, evtPwrBtn = 0, evtRtcAlarm = 0;
  logic powerDownReq = 0, evtHotplug = 0;
  logic sci, tmrArm;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sci_event_agg i_sci_event_agg (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regBank(regBank), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtTmrOvf(evtTmrOvf),
    .evtGlobalLock(evtGlobalLock), .evtPwrBtn(evtPwrBtn), .evtRtcAlarm(evtRtcAlarm),
    .powerDownReq(powerDownReq), .evtHotplug(evtHotplug), .sci(sci), .tmrArm(tmrArm)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // write takes effect at the posedge between the two negedges
  task automatic wr(input logic bank, input int addr, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regBank = bank; regAddr = ADDR_W'(addr); regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic bank, input int addr, output int v);
    regBank = bank; regAddr = ADDR_W'(addr);
    #1 v = int'(regRdData);
  endtask

  task automatic chkReg(input string req, input logic bank, input int addr, input int exp);
    int v;
    rd(bank, addr, v);
    check(req, v, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evtTmrOvf = 1; 1: evtGlobalLock = 1; 2: evtPwrBtn = 1;
      3: evtRtcAlarm = 1; 4: powerDownReq = 1; default: evtHotplug = 1;
    endcase
    @(negedge clk);
    {evtTmrOvf, evtGlobalLock, evtPwrBtn, evtRtcAlarm, powerDownReq, evtHotplug} = '0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) begin
      chkReg("R1 gpe byte", 0, a, 0);
      chkReg("R1 pm1 byte", 1, a, 0);
    end
    check("R1 sci", sci, 0);
    check("R1 tmrArm", tmrArm, 0);
  endtask

  task automatic t_gpeLayout();
    wr(0, 2, 8'hA5);
    wr(0, 3, 8'h3C);
    chkReg("R2 en byte0", 0, 2, 'hA5);
    chkReg("R2 en byte1", 0, 3, 'h3C);
    chkReg("R2 sts byte0", 0, 0, 0);
    wr(0, 0, 8'hFF);
    chkReg("R4 sw cannot set", 0, 0, 0);
    wr(0, 2, 8'h00);
    wr(0, 3, 8'hFF);
    pulse(5);
    check("R12 en byte1 ignored", sci, 0);
    wr(0, 3, 8'h00);
    wr(0, 0, 8'h02);
  endtask

  task automatic t_hotplug();
    pulse(5);
    chkReg("R10 hotplug sts", 0, 0, 'h02);
    chkReg("R10 byte1 untouched", 0, 1, 0);
    check("R6 no enable", sci, 0);
    wr(0, 2, 8'h02);
    check("R6 enabled", sci, 1);
    wr(0, 0, 8'h00);
    chkReg("R4 zero write keeps", 0, 0, 'h02);
    check("R4 sci kept", sci, 1);
    wr(0, 0, 8'h02);
    chkReg("R4 w1c", 0, 0, 0);
    check("R7 sci drops", sci, 0);
  endtask

  task automatic t_pm1();
    wr(1, 2, 8'h21);
    wr(1, 3, 8'h05);
    chkReg("R3 en lo", 1, 2, 'h21);
    chkReg("R3 en hi", 1, 3, 'h05);
    check("R8 armed", tmrArm, 1);
    check("R5 enable only", sci, 0);
    pulse(3);
    chkReg("R3 rtc bit10", 1, 1, 'h04);
    check("R5 rtc sci", sci, 1);
    wr(1, 1, 8'h04);
    check("R5 rtc cleared", sci, 0);
    pulse(1);
    chkReg("R3 glbl bit5", 1, 0, 'h20);
    check("R5 glbl sci", sci, 1);
    wr(1, 0, 8'h20);
    pulse(0);
    chkReg("R3 tmr bit0", 1, 0, 'h01);
    check("R8 disarmed", tmrArm, 0);
    check("R5 tmr sci", sci, 1);
    wr(1, 0, 8'h01);
    check("R8 rearmed", tmrArm, 1);
    pulse(4);
    chkReg("R9 powerdown sets pwrbtn", 1, 1, 'h01);
    check("R9 sci", sci, 1);
    wr(1, 1, 8'h01);
    pulse(2);
    chkReg("R3 pwrbtn bit8", 1, 1, 'h01);
    wr(1, 1, 8'h01);
    check("R7 idle", sci, 0);
  endtask

  task automatic t_orAndRace();
    pulse(5);
    pulse(3);
    wr(1, 1, 8'h04);
    check("R7 gpe alone holds", sci, 1);
    wr(0, 0, 8'h02);
    check("R7 both cleared", sci, 0);
    @(negedge clk);
    evtTmrOvf = 1; regWrEn = 1; regBank = 1; regAddr = 2'd0; regWrData = 8'h01;
    @(negedge clk);
    evtTmrOvf = 0; regWrEn = 0;
    chkReg("R11 event wins", 1, 0, 'h01);
    check("R11 tmrArm low", tmrArm, 0);
    wr(1, 0, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_gpeLayout();
    t_hotplug();
    t_pm1();
    t_orAndRace();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule